// File: doc/BRIEF.md
# Maskable Interrupt Request Collector

This block gathers up to eight hardware interrupt sources into one request line for an upstream interrupt controller. A pending register records which sources have asked for service. Hardware sets bits in it with a post vector and removes bits with a clear vector. Software removes single bits by writing their index to an acknowledge port.

An enable mask, written by software, decides which pending bits may raise the request line. The mask port uses an inverted sense: software writes a 1 to block a line. The register stores the complement of what was written, and a read of the port returns the written value again. Software can also read the pending register. A second status address answers with zero, so code written for a paired controller sees no requests from the missing second half.

Top module: `irq_collector`

## Requirements
- R1: After synchronous reset the pending register is zero, every line is disabled (stored enable mask all zeros), and both irq_out and rd_data are 0.
- R2: A write to address 2'b00 stores the bitwise inverse of wr_data as the enable mask, so a line whose written bit is 1 never raises irq_out.
- R3: A read of address 2'b00 returns the complement of the stored enable mask, which equals the byte last written there (0xFF after reset).
- R4: irq_out is a register that is high exactly when pending AND enable is non-zero. It takes the new value on the same clock edge that changes either of them, including a mask write.
- R5: A write to address 2'b10 clears the pending bit whose index is wr_data[3:0]. An index of WIDTH or more changes nothing, and the upper data bits are ignored.
- R6: hw_post bits are ORed into the pending register and hw_clear bits are removed from it, on the clock edge where they are present.
- R7: When a bit is posted in the same cycle in which it is cleared by hw_clear or by an acknowledge, it ends up set.
- R8: A read of address 2'b01 returns the pending register. Reads of addresses 2'b10 and 2'b11 return 0x00. Writes to 2'b01 and 2'b11 change nothing.
- R9: rd_data is registered: it shows the value from the state before the edge at which rd_en was sampled, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 00 mask, 01 status, 10 acknowledge, 11 secondary status |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Registered read data |
| hw_post | input | WIDTH | Hardware request set vector |
| hw_clear | input | WIDTH | Hardware request clear vector |
| irq_out | output | 1 | Request line to the upstream controller |

## Verification
Every result is due one edge after its stimulus. A post, a clear, an acknowledge or a mask write shows on irq_out after the edge that samples it. A read shows on rd_data after the edge that samples rd_en, and it carries the state from before that edge. The bench drives inputs on the falling edge and compares both outputs on the following falling edge against a model it advances once per rising edge. Every comparison therefore lands exactly one register stage after its cause. Directed cases cover the inverted mask, out-of-range acknowledge indices, post against clear on the same bit, and the secondary status read. Random traffic then covers everything else.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    IRQC_MASK = 2'd0,
    IRQC_STAT = 2'd1,
    IRQC_ACK  = 2'd2,
    IRQC_SEC  = 2'd3
  } irqc_reg_e;
  localparam int IRQC_IDX_W = 4;
endpackage

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [1:0]            reg_addr,
  input  logic [WIDTH-1:0]      wr_data,
  input  logic [WIDTH-1:0]      pend_q,
  input  logic [WIDTH-1:0]      en_q,
  output logic                  mask_we,
  output logic                  ack_we,
  output logic [IRQC_IDX_W-1:0] ack_idx,
  output logic [WIDTH-1:0]      rd_data
);
  irqc_reg_e        sel;
  logic [WIDTH-1:0] rd_mux;

  assign sel     = irqc_reg_e'(reg_addr);
  assign mask_we = wr_en && (sel == IRQC_MASK);
  assign ack_we  = wr_en && (sel == IRQC_ACK);
  assign ack_idx = wr_data[IRQC_IDX_W-1:0];

  always_comb begin
    unique case (sel)
      IRQC_MASK: rd_mux = ~en_q;
      IRQC_STAT: rd_mux = pend_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] en_q,
  output logic [WIDTH-1:0] en_next
);
  assign en_next = mask_we ? ~wr_data : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_next;
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WIDTH-1:0]      hw_post,
  input  logic [WIDTH-1:0]      hw_clear,
  input  logic                  ack_we,
  input  logic [IRQC_IDX_W-1:0] ack_idx,
  output logic [WIDTH-1:0]      pend_q,
  output logic [WIDTH-1:0]      pend_next
);
  logic [WIDTH-1:0] ack_vec;

  // One decoder bit per line; indices outside the width match nothing.
  for (genvar i = 0; i < WIDTH; i++) begin : g_ack
    assign ack_vec[i] = ack_we && (ack_idx == IRQC_IDX_W'(i));
  end

  // Set takes priority over both kinds of removal.
  assign pend_next = (pend_q & ~hw_clear & ~ack_vec) | hw_post;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_next;
  end
endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] hw_post,
  input  logic [WIDTH-1:0] hw_clear,
  output logic             irq_out
);
  logic                             mask_we, ack_we;
  logic [irqc_pkg::IRQC_IDX_W-1:0]  ack_idx;
  logic [WIDTH-1:0]                 pend_q, pend_next, en_q, en_next;

  irqc_regif #(.WIDTH(WIDTH)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .wr_data(wr_data),
    .pend_q(pend_q), .en_q(en_q),
    .mask_we(mask_we), .ack_we(ack_we), .ack_idx(ack_idx),
    .rd_data(rd_data)
  );

  irqc_mask #(.WIDTH(WIDTH)) u_mask (
    .clk(clk), .rst(rst), .mask_we(mask_we), .wr_data(wr_data),
    .en_q(en_q), .en_next(en_next)
  );

  irqc_pending #(.WIDTH(WIDTH)) u_pend (
    .clk(clk), .rst(rst), .hw_post(hw_post), .hw_clear(hw_clear),
    .ack_we(ack_we), .ack_idx(ack_idx),
    .pend_q(pend_q), .pend_next(pend_next)
  );

  // Evaluated on next-state values so a mask write acts on the same edge.
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_next & en_next);
  end
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       reg_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] hw_post,
  input logic [WIDTH-1:0] hw_clear,
  input logic             irq_out,
  input logic [WIDTH-1:0] pend_q,
  input logic [WIDTH-1:0] en_q
);
  // R4
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(pend_q & en_q));

  // R7
  post_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_post != '0) |=> ((pend_q & $past(hw_post)) == $past(hw_post)));

  // R6
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    ((hw_clear & ~hw_post) != '0) |=> ((pend_q & $past(hw_clear & ~hw_post)) == '0));

  // R2
  mask_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr == 2'b00) |=> (en_q == ~$past(wr_data)));

  // R8
  sec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == 2'b11) |=> (rd_data == '0));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind irq_collector irq_collector_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
  .wr_data(wr_data), .rd_data(rd_data), .hw_post(hw_post),
  .hw_clear(hw_clear), .irq_out(irq_out), .pend_q(pend_q), .en_q(en_q)
);

// File: tb/irq_collector_tb.sv
module irq_collector_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic [W-1:0] wr_data = '0, hw_post = '0, hw_clear = '0;
  logic [W-1:0] rd_data;
  logic         irq_out;

  int n_chk = 0, n_bad = 0;

  logic [W-1:0] m_pend, m_en, m_rd;
  logic         m_irq;

  always #5 clk = ~clk;

  irq_collector #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .hw_post(hw_post),
    .hw_clear(hw_clear), .irq_out(irq_out)
  );

  function automatic logic [W-1:0] read_val(logic [1:0] a, logic [W-1:0] p, logic [W-1:0] e);
    case (a)
      2'b00:   return ~e;
      2'b01:   return p;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] ack_vec(logic we, logic [W-1:0] d);
    logic [W-1:0] v = '0;
    if (we && d[3:0] < 4'(W)) v[d[3:0]] = 1'b1;
    return v;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive on falling edge, advance model at the rising edge, compare next fall.
  task automatic step(string tag, logic we, logic re, logic [1:0] a,
                      logic [W-1:0] d, logic [W-1:0] p, logic [W-1:0] c);
    wr_en = we; rd_en = re; reg_addr = a; wr_data = d; hw_post = p; hw_clear = c;
    if (re) m_rd = read_val(a, m_pend, m_en);
    if (we && a == 2'b00) m_en = ~d;
    m_pend = (m_pend & ~c & ~ack_vec(we && a == 2'b10, d)) | p;
    m_irq  = |(m_pend & m_en);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " irq"}, W'(irq_out), W'(m_irq));
    chk({tag, " rd"}, rd_data, m_rd);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_pend = '0; m_en = '0; m_rd = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", W'(irq_out), '0);
    chk("R1 rd", rd_data, '0);
    step("R1 mask read", 0, 1, 2'b00, '0, '0, '0);   // R3 reads 0xFF
    step("R1 status read", 0, 1, 2'b01, '0, '0, '0);
    // R1/R2: posting with everything disabled leaves irq low
    step("R2 disabled post", 0, 0, 2'b00, '0, 8'h10, '0);
    // R2/R4: enabling line 4 raises irq on that edge
    step("R4 enable", 1, 0, 2'b00, 8'hEF, '0, '0);
    step("R3 readback", 0, 1, 2'b00, '0, '0, '0);
    // R2: writing 1 disables the line, irq drops
    step("R2 disable", 1, 0, 2'b00, 8'hFF, '0, '0);
    step("R4 enable all", 1, 0, 2'b00, 8'h00, '0, '0);
    // R5: out-of-range indices change nothing
    step("R5 idx9", 1, 0, 2'b10, 8'h09, '0, '0);
    step("R5 idx15", 1, 0, 2'b10, 8'h0F, '0, '0);
    step("R5 status", 0, 1, 2'b01, '0, '0, '0);
    // R5: upper nibble ignored, index 4 cleared
    step("R5 ack4", 1, 0, 2'b10, 8'hF4, '0, '0);
    step("R5 status2", 0, 1, 2'b01, '0, '0, '0);
    // R6: post and clear
    step("R6 post", 0, 0, 2'b00, '0, 8'hA5, '0);
    step("R6 clear", 0, 1, 2'b01, '0, '0, 8'h05);
    step("R6 status", 0, 1, 2'b01, '0, '0, '0);
    // R7: post beats clear and ack
    step("R7 post vs clear", 0, 0, 2'b00, '0, 8'h02, 8'h02);
    step("R7 post vs ack", 1, 0, 2'b10, 8'h07, 8'h80, '0);
    step("R7 status", 0, 1, 2'b01, '0, '0, '0);
    // R8: secondary/ack reads zero, writes there ignored
    step("R8 sec write", 1, 0, 2'b11, 8'hFF, '0, '0);
    step("R8 stat write", 1, 0, 2'b01, 8'h00, '0, '0);
    step("R8 sec read", 0, 1, 2'b11, '0, '0, '0);
    step("R8 ack read", 0, 1, 2'b10, '0, '0, '0);
    step("R8 status", 0, 1, 2'b01, '0, '0, '0);
    // R9: read reflects pre-edge state, held without rd_en
    step("R9 read with post", 0, 1, 2'b01, '0, 8'h01, '0);
    step("R9 hold", 0, 0, 2'b00, '0, '0, 8'hFF);
    // random mix covering R2..R9
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] p, c;
      p = W'($urandom) & W'($urandom) & W'($urandom);
      c = W'($urandom) & W'($urandom);
      step("R4 random", ($urandom % 3) == 0, ($urandom % 2) == 0,
           2'($urandom), W'($urandom), p, c);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule